// File: doc/BRIEF.md
# Stream Buffer Unit

This block sits between one processor and a central memory scheduler. It holds a small set of stream queues. Each queue is bound to one stream and is set as either a read stream or a write stream. The processor sees two memory-mapped words per stream: a setup word that holds the direction and the active depth, and a head word. A load from a read stream's head word takes the oldest element. A store to a write stream's head word appends one. The processor walks each queue strictly in order, one element per loop pass.

On the memory side the scheduler picks slots by index, in whatever order suits the DRAM pages. It fills empty slots of read streams and drains occupied slots of write streams. A per-slot readiness vector tells the scheduler which slots it may service. The processor access is a single-cycle request. When it cannot complete, `cpu_wait` is raised in the same cycle and nothing changes; the processor repeats the request later.

The active depth of each queue can be changed at run time, from 1 up to the built size. This allows depths smaller than the memory bank count.

Top module: `stream_buffer_unit`

## Requirements
- R1: After reset, every stream is a read stream with depth MD, no slot holds data, every bit of `slot_ready` is 1 and `cpu_wait` is 0.
- R2: The setup word of stream s sits at address {s, 1}. Its bit 0 is the direction (1 = write stream) and bits [DPW:1] are the depth. A write to it takes effect only when the depth is from 1 to MD, no slot of that stream holds data, and no fill to that stream is accepted in the same cycle. Any other write leaves the word unchanged. A load returns the current word.
- R3: A fill is accepted only for a read stream, a slot index below the active depth, and a slot that is empty. An accepted fill stores the data and marks the slot full. Any other fill changes nothing.
- R4: A load from the head word {s, 0} of a read stream returns the data of the head slot, empties that slot and moves the head to the next slot. Slots are taken in the order 0, 1, ..., depth-1, then 0 again.
- R5: A load from a read head whose slot is empty raises `cpu_wait` and changes nothing, even if later slots are full. `cpu_wait` is never raised for a setup-word access.
- R6: A store to a write stream's head word puts the data in the tail slot and advances the tail in the same cyclic order as R4. If the tail slot still holds data, `cpu_wait` is raised and nothing changes.
- R7: `drain_data` shows the addressed slot's data when that slot of a write stream is full, and 0 otherwise. A drain of a full write slot empties it. Any other drain changes nothing.
- R8: The bit `slot_ready[s*MD+k]` is 1 for a read stream when k is below the depth and slot k is empty. For a write stream it is 1 when slot k is full.
- R9: A store to a read stream's head and a load from a write stream's head are ignored. `cpu_wait` stays 0, the load returns 0 and no slot changes.
- R10: A processor head access and a fill or drain on different slots of the same stream in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor load request (never together with cpu_wr) |
| cpu_wr | input | 1 | Processor store request |
| cpu_addr | input | AW | {stream, word}: word 0 = head, 1 = setup |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Load data, valid when the request does not wait |
| cpu_wait | output | 1 | Request cannot complete this cycle |
| fill_en | input | 1 | Scheduler writes a read-stream slot |
| fill_stream | input | SW | Stream of the fill |
| fill_slot | input | PW | Slot of the fill |
| fill_data | input | DW | Data of the fill |
| drain_en | input | 1 | Scheduler empties a write-stream slot |
| drain_stream | input | SW | Stream of the drain |
| drain_slot | input | PW | Slot of the drain |
| drain_data | output | DW | Data of the addressed drain slot |
| slot_ready | output | NS*MD | Per-slot service readiness |

## Verification
The processor side and the scheduler side share the slot flags, so their collisions are the core risk. A load taking the head slot while a fill lands two slots further on must leave both effects in place. A store to the tail slot issued in the same cycle as a drain of an older slot must also keep both effects. The bench provokes these collisions by driving both sides on one falling edge. It then judges the returned data and the readiness vector one cycle later against its own slot model. It also provokes a setup write arriving together with a fill and expects the write to be refused. Each depth from 1 to the maximum is swept with fills in reverse order to prove in-order delivery.

// File: rtl/stream_buffer_unit.sv
module stream_buffer_unit #(
  parameter int NS = 2,
  parameter int MD = 4,
  parameter int DW = 8,
  localparam int SW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int PW  = (MD > 1) ? $clog2(MD) : 1,
  localparam int DPW = $clog2(MD + 1),
  localparam int AW  = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_wait,
  input  logic          fill_en,
  input  logic [SW-1:0] fill_stream,
  input  logic [PW-1:0] fill_slot,
  input  logic [DW-1:0] fill_data,
  input  logic          drain_en,
  input  logic [SW-1:0] drain_stream,
  input  logic [PW-1:0] drain_slot,
  output logic [DW-1:0] drain_data,
  output logic [NS*MD-1:0] slot_ready
);

  logic [DW-1:0]  data_q [NS][MD];
  logic [MD-1:0]  vld_q  [NS];
  logic [DPW-1:0] dep_q  [NS];
  logic [PW-1:0]  ptr_q  [NS];
  logic [NS-1:0]  dir_q;

  wire [SW-1:0]  sel       = cpu_addr[AW-1:1];
  wire           cfg_sel   = cpu_addr[0];
  wire [PW-1:0]  hptr      = ptr_q[sel];
  wire           head_full = vld_q[sel][hptr];
  wire           hd_rd     = cpu_rd && !cfg_sel && !dir_q[sel];
  wire           hd_wr     = cpu_wr && !cfg_sel && dir_q[sel];
  wire           deq       = hd_rd && head_full;
  wire           enq       = hd_wr && !head_full;
  wire [PW-1:0]  hnext     = (DPW'(hptr) + 1'b1 == dep_q[sel]) ? '0 : hptr + 1'b1;
  wire [DPW-1:0] new_dep   = cpu_wdata[DPW:1];

  wire fill_ok  = fill_en && !dir_q[fill_stream] &&
                  (DPW'(fill_slot) < dep_q[fill_stream]) &&
                  !vld_q[fill_stream][fill_slot];
  wire drain_ok = drain_en && dir_q[drain_stream] && vld_q[drain_stream][drain_slot];
  wire cfg_ok   = cpu_wr && cfg_sel && (vld_q[sel] == '0) &&
                  !(fill_ok && fill_stream == sel) &&
                  (new_dep != '0) && (new_dep <= DPW'(MD));

  assign cpu_wait   = (hd_rd && !head_full) || (hd_wr && head_full);
  assign cpu_rdata  = cfg_sel ? DW'({dep_q[sel], dir_q[sel]}) :
                      deq     ? data_q[sel][hptr] : '0;
  assign drain_data = (dir_q[drain_stream] && vld_q[drain_stream][drain_slot]) ?
                      data_q[drain_stream][drain_slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      for (int s = 0; s < NS; s++) begin
        vld_q[s] <= '0;
        dep_q[s] <= DPW'(MD);
        ptr_q[s] <= '0;
      end
    end else begin
      if (fill_ok)  vld_q[fill_stream][fill_slot]   <= 1'b1;
      if (drain_ok) vld_q[drain_stream][drain_slot] <= 1'b0;
      if (deq || enq) begin
        vld_q[sel][hptr] <= enq;
        ptr_q[sel]       <= hnext;
      end
      if (cfg_ok) begin
        dir_q[sel] <= cpu_wdata[0];
        dep_q[sel] <= new_dep;
        ptr_q[sel] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) data_q[fill_stream][fill_slot] <= fill_data;
    if (enq)     data_q[sel][hptr]              <= cpu_wdata;
  end

  for (genvar s = 0; s < NS; s++) begin : g_str
    for (genvar k = 0; k < MD; k++) begin : g_slot
      assign slot_ready[s*MD+k] = dir_q[s] ? vld_q[s][k] :
                                  ((DPW'(k) < dep_q[s]) && !vld_q[s][k]);
    end
  end

endmodule

// File: rtl/sbu_chk.sv
module sbu_chk #(
  parameter int NS = 2,
  parameter int MD = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int PW = (MD > 1) ? $clog2(MD) : 1,
  localparam int AW = SW + 1,
  localparam int IW = (NS*MD > 1) ? $clog2(NS*MD) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rd,
  input logic             cpu_wr,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_wait,
  input logic             fill_en,
  input logic [SW-1:0]    fill_stream,
  input logic [PW-1:0]    fill_slot,
  input logic             drain_en,
  input logic [SW-1:0]    drain_stream,
  input logic [PW-1:0]    drain_slot,
  input logic [NS*MD-1:0] slot_ready,
  input logic [NS-1:0]    dir_q
);
  wire [SW-1:0] sel  = cpu_addr[AW-1:1];
  wire [IW-1:0] fidx = IW'(int'(fill_stream) * MD + int'(fill_slot));
  wire [IW-1:0] didx = IW'(int'(drain_stream) * MD + int'(drain_slot));
  wire stray = !cpu_addr[0] && ((cpu_wr && !dir_q[sel]) || (cpu_rd && dir_q[sel]));

  // R3
  fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !dir_q[fill_stream] && slot_ready[fidx] |=> !slot_ready[$past(fidx)]);

  // R7
  drain_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_en && dir_q[drain_stream] && slot_ready[didx] |=> !slot_ready[$past(didx)]);

  // R6
  enq_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !cpu_addr[0] && dir_q[sel] && !cpu_wait && !fill_en && !drain_en
    |=> $countones(slot_ready) == $past($countones(slot_ready)) + 1);

  // R9
  stray_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray && !fill_en && !drain_en |=> $stable(slot_ready));

  // R9
  stray_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray |-> !cpu_wait);

  // R5
  cfg_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[0] |-> !cpu_wait);
endmodule

bind stream_buffer_unit sbu_chk #(.NS(NS), .MD(MD)) u_sbu_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wait(cpu_wait), .fill_en(fill_en), .fill_stream(fill_stream),
  .fill_slot(fill_slot), .drain_en(drain_en), .drain_stream(drain_stream),
  .drain_slot(drain_slot), .slot_ready(slot_ready), .dir_q(dir_q)
);

// File: tb/test_stream_buffer_unit.sv
`timescale 1ns/1ps
module test_stream_buffer_unit;
  logic clk = 0, rst_n = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, fill_data = 0, drain_data;
  logic cpu_wait, fill_en = 0, drain_en = 0;
  logic [0:0] fill_stream = 0, drain_stream = 0;
  logic [1:0] fill_slot = 0, drain_slot = 0;
  logic [7:0] slot_ready;

  stream_buffer_unit #(.NS(2), .MD(4), .DW(8)) i_stream_buffer_unit (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .fill_en(fill_en), .fill_stream(fill_stream), .fill_slot(fill_slot),
    .fill_data(fill_data), .drain_en(drain_en), .drain_stream(drain_stream),
    .drain_slot(drain_slot), .drain_data(drain_data), .slot_ready(slot_ready));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit mv [2][4];
  bit mdir [2];
  int mdep [2];
  logic [7:0] rdv, dd;
  bit w;

  function automatic logic [7:0] exp_ready();
    logic [7:0] r;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++)
        r[s*4+k] = mdir[s] ? mv[s][k] : ((k < mdep[s]) && !mv[s][k]);
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_ready(input string tag);
    check(tag, slot_ready, exp_ready());
  endtask

  task automatic cpu_op(input bit rd, input bit wr, input int s, input bit cfg,
                        input logic [7:0] wd);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = {s[0], cfg}; cpu_wdata = wd;
    #1; rdv = cpu_rdata; w = cpu_wait;
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic fill(input int s, input int k, input logic [7:0] d);
    @(negedge clk);
    fill_en = 1; fill_stream = s[0]; fill_slot = k[1:0]; fill_data = d;
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic drain(input int s, input int k);
    @(negedge clk);
    drain_en = 1; drain_stream = s[0]; drain_slot = k[1:0];
    #1; dd = drain_data;
    @(posedge clk); #1;
    drain_en = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got hang expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] a, b, c;
    for (int s = 0; s < 2; s++) begin
      mdir[s] = 0; mdep[s] = 4;
      for (int k = 0; k < 4; k++) mv[s][k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    check("R1 ready after reset", slot_ready, 8'hFF);
    check("R1 wait after reset", cpu_wait, 0);
    cpu_op(1, 0, 0, 1, 0); check("R1 setup s0", rdv, 8'h08);
    cpu_op(1, 0, 1, 1, 0); check("R1 setup s1", rdv, 8'h08);

    // sweep every depth on stream 0, fills in reverse order
    for (int d = 1; d <= 4; d++) begin
      cpu_op(0, 1, 0, 1, 8'(d << 1)); mdep[0] = d;
      cpu_op(1, 0, 0, 1, 0); check("R2 depth readback", rdv, d << 1);
      check_ready("R8 ready at new depth");
      for (int r = 0; r < 2; r++) begin
        for (int k = d - 1; k >= 1; k--) begin
          fill(0, k, 8'(8'h40 + d*16 + r*8 + k)); mv[0][k] = 1;
          check_ready("R3 fill marks slot");
        end
        if (d > 1) begin
          cpu_op(1, 0, 0, 0, 0);
          check("R5 wait on empty head", w, 1);
          check_ready("R5 stalled load no change");
        end
        if (d < 4) begin
          fill(0, d, 8'hEE);
          check_ready("R3 fill beyond depth ignored");
        end
        fill(0, 0, 8'(8'h40 + d*16 + r*8)); mv[0][0] = 1;
        fill(0, 0, 8'hDD);
        check_ready("R3 fill of full slot ignored");
        for (int k = 0; k < d; k++) begin
          cpu_op(1, 0, 0, 0, 0); mv[0][k] = 0;
          check("R4 load no wait", w, 0);
          check("R4 in-order data", rdv, 8'h40 + d*16 + r*8 + k);
          check_ready("R4 head slot emptied");
        end
      end
    end

    // setup rejections, head pointer now 0, depth 4
    cpu_op(0, 1, 0, 1, 8'h00);
    cpu_op(1, 0, 0, 1, 0); check("R2 depth 0 rejected", rdv, 8'h08);
    cpu_op(0, 1, 0, 1, 8'h0A);
    cpu_op(1, 0, 0, 1, 0); check("R2 depth 5 rejected", rdv, 8'h08);
    fill(0, 2, 8'h62); mv[0][2] = 1;
    cpu_op(0, 1, 0, 1, 8'h04);
    cpu_op(1, 0, 0, 1, 0); check("R2 non-empty rejected", rdv, 8'h08);
    fill(0, 0, 8'h60); mv[0][0] = 1;
    fill(0, 1, 8'h61); mv[0][1] = 1;
    for (int k = 0; k < 3; k++) begin
      cpu_op(1, 0, 0, 0, 0); mv[0][k] = 0;
      check("R4 data after reject", rdv, 8'h60 + k);
    end

    // setup write racing a fill on the same stream (head at 3)
    @(negedge clk);
    cpu_wr = 1; cpu_addr = 2'b01; cpu_wdata = 8'h06;
    fill_en = 1; fill_stream = 0; fill_slot = 3; fill_data = 8'h73;
    @(posedge clk); #1; cpu_wr = 0; fill_en = 0; mv[0][3] = 1;
    cpu_op(1, 0, 0, 1, 0); check("R2 setup refused with fill", rdv, 8'h08);
    check_ready("R2 racing fill kept");
    cpu_op(1, 0, 0, 0, 0); mv[0][3] = 0; check("R2 racing fill data", rdv, 8'h73);

    // load and fill in the same cycle (head at 0)
    fill(0, 0, 8'h80); mv[0][0] = 1;
    fill(0, 1, 8'h81); mv[0][1] = 1;
    @(negedge clk);
    cpu_rd = 1; cpu_addr = 2'b00;
    fill_en = 1; fill_stream = 0; fill_slot = 2; fill_data = 8'h82;
    #1; a = cpu_rdata; w = cpu_wait;
    @(posedge clk); #1; cpu_rd = 0; fill_en = 0; mv[0][0] = 0; mv[0][2] = 1;
    check("R10 load with fill data", a, 8'h80);
    check("R10 load with fill no wait", w, 0);
    check_ready("R10 both effects");
    cpu_op(1, 0, 0, 0, 0); mv[0][1] = 0; check("R10 next load", rdv, 8'h81);
    cpu_op(1, 0, 0, 0, 0); mv[0][2] = 0; check("R10 filled slot load", rdv, 8'h82);

    // stream 1 as write stream, depth 3
    cpu_op(0, 1, 1, 1, 8'h07); mdir[1] = 1; mdep[1] = 3;
    cpu_op(1, 0, 1, 1, 0); check("R2 write setup readback", rdv, 8'h07);
    check_ready("R8 write stream empty");
    for (int k = 0; k < 3; k++) begin
      cpu_op(0, 1, 1, 0, 8'(8'hA0 + k)); mv[1][k] = 1;
      check("R6 store no wait", w, 0);
      check_ready("R6 store fills tail");
    end
    cpu_op(0, 1, 1, 0, 8'hFF);
    check("R6 store waits when full", w, 1);
    check_ready("R6 stalled store no change");
    drain(1, 1); mv[1][1] = 0;
    check("R7 drain data out of order", dd, 8'hA1);
    check_ready("R7 drain frees slot");
    cpu_op(0, 1, 1, 0, 8'hFF);
    check("R6 tail still occupied", w, 1);
    drain(1, 1);
    check("R7 empty slot drain data", dd, 0);
    check_ready("R7 empty drain ignored");
    drain(1, 0); mv[1][0] = 0; check("R7 drain slot 0", dd, 8'hA0);
    cpu_op(0, 1, 1, 0, 8'hB0); mv[1][0] = 1; check("R6 wrap store", w, 0);
    cpu_op(0, 1, 1, 0, 8'hB1); mv[1][1] = 1; check("R6 next store", w, 0);
    cpu_op(0, 1, 1, 0, 8'hFF); check("R6 wait at slot 2", w, 1);
    drain(1, 2); mv[1][2] = 0; check("R7 drain slot 2", dd, 8'hA2);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = 2'b10; cpu_wdata = 8'hC2;
    drain_en = 1; drain_stream = 1; drain_slot = 0;
    #1; b = drain_data; w = cpu_wait;
    @(posedge clk); #1; cpu_wr = 0; drain_en = 0; mv[1][0] = 0; mv[1][2] = 1;
    check("R10 drain with store data", b, 8'hB0);
    check("R10 store with drain no wait", w, 0);
    check_ready("R10 store and drain both");
    drain(1, 1); mv[1][1] = 0; check("R7 drain B1", dd, 8'hB1);
    drain(1, 2); mv[1][2] = 0; check("R7 drain C2", dd, 8'hC2);

    // stray accesses (stream 0 head at 3)
    cpu_op(0, 1, 0, 0, 8'h55);
    check("R9 store to read head no wait", w, 0);
    check_ready("R9 store to read head ignored");
    cpu_op(1, 0, 1, 0, 0);
    check("R9 load from write head data", rdv, 0);
    check("R9 load from write head no wait", w, 0);
    check_ready("R9 load from write head ignored");
    fill(1, 0, 8'h99);
    check_ready("R3 fill on write stream ignored");
    fill(0, 3, 8'h93); mv[0][3] = 1;
    drain(0, 3);
    check("R7 drain on read stream data", dd, 0);
    check_ready("R7 drain on read stream ignored");
    cpu_op(1, 0, 0, 0, 0); mv[0][3] = 0;
    check("R7 read slot survived drain", rdv, 8'h93);
    c = 0;
    check_ready("R8 final readiness");
    finish_up();
  end
endmodule